// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by reading descriptors from an in-memory translation table. A walk reads one descriptor, or two when the first points at a second-level table. Four mapping sizes come out of the same walker: 1 MB sections, 16 MB supersections, 64 KB large pages and 4 KB small pages. A supersection gives a 40-bit physical address. Two table base values are supplied, and a split control value N picks between them for each request.

A TLB hands a missing virtual address to the request port and receives the translated address, the mapping kind, or a translation fault with its level on the response port. Both ports use valid/ready. A request is taken only while the walker is idle, so `req_ready` is low for the whole of a walk and while a response is held. The response stays valid and unchanged until `rsp_ready` is seen high. The memory read port allows one read at a time: the address is held until `mem_req_ready`, and the data arrives later as a single `mem_rsp_valid` pulse that cannot be back-pressured.

Top module: `xw_walker`

## Requirements
- R1: If the top N bits of the virtual address are all zero, or N is 0, the first-level table base is `ctl_base0`; otherwise it is `ctl_base1`. The first-level read address is that base plus VA[31:20] times 4.
- R2: A first-level descriptor is decoded from bits [1:0]: 00 and 11 are faults, 01 is a second-level table pointer, and 10 is a block mapping. For a block mapping, bit 18 set means supersection and clear means section.
- R3: For a section, the physical address is {8'h00, desc[31:20], VA[19:0]} and the kind is 0.
- R4: For a supersection, the physical address is {desc[15:8], desc[31:24], VA[23:0]} and the kind is 1.
- R5: After a pointer descriptor, the second-level read address is {desc[31:10], 10'b0} plus VA[19:12] times 4.
- R6: A second-level descriptor with bits [1:0] = 1x is a small page. Its physical address is {8'h00, desc[31:12], VA[11:0]} and its kind is 3.
- R7: A second-level descriptor with bits [1:0] = 01 is a large page. Its physical address is {8'h00, desc[31:16], VA[15:0]} and its kind is 2.
- R8: A fault descriptor ends the walk with `rsp_fault` high, `rsp_fault_lvl` 0 for the first level or 1 for the second, and a physical address of zero. A second-level descriptor with bits [1:0] = 00 is a fault.
- R9: Every successful result other than a supersection has physical address bits [39:32] equal to zero.
- R10: The memory request address is held stable until it is accepted. The response is held stable until `rsp_ready`. `req_ready` is low while a response is pending.
- R11: A walk issues exactly one memory read when the first-level descriptor is a fault or a block mapping, and exactly two reads otherwise. Only one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_split_n | input | 3 | Split value N for base selection |
| ctl_base0 | input | 32 | Table base used for the low address region |
| ctl_base1 | input | 32 | Table base used for the high address region |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_pa | output | 40 | Physical address, zero on a fault |
| rsp_kind | output | 2 | 0 section, 1 supersection, 2 large page, 3 small page |
| rsp_fault | output | 1 | Translation fault |
| rsp_fault_lvl | output | 1 | Level of the fault: 0 first, 1 second |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Read data pulse |
| mem_rsp_data | input | 32 | Descriptor word |

## Verification
On every cycle, the assertions check that the memory address stays stable under stall, that a held response does not change, that requests are refused while a result is pending, and that fault results carry a zero address and non-supersection results carry zero upper bits. Only the bench scenarios can show the rest. That covers the choice of base for each N and address pattern, the exact first- and second-level read addresses, the bit fields assembled for each of the four mapping sizes, the fault level, and the count of reads per walk. The bench sweeps all eight N values against addresses on both sides of each split and against every descriptor type.

// File: rtl/xw_pkg.sv
package xw_pkg;
  typedef enum logic [1:0] {
    KIND_SECTION = 2'd0,
    KIND_SUPER   = 2'd1,
    KIND_LARGE   = 2'd2,
    KIND_SMALL   = 2'd3
  } xw_kind_e;

  typedef struct packed {
    logic        fault;
    logic        next;
    xw_kind_e    kind;
    logic [39:0] pa;
    logic [31:0] l2_base;
  } xw_dec_t;
endpackage

// File: rtl/xw_base_sel.sv
module xw_base_sel #(
  parameter int VA_W   = 32,
  parameter int NSEL_W = 3
) (
  input  logic [VA_W-1:0]   va,
  input  logic [NSEL_W-1:0] split_n,
  input  logic [VA_W-1:0]   base0,
  input  logic [VA_W-1:0]   base1,
  output logic [VA_W-1:0]   base
);
  logic [VA_W-1:0] top_mask;
  logic            hi_region;

  always_comb begin
    top_mask  = ~({VA_W{1'b1}} >> split_n);
    hi_region = |(va & top_mask);
    base      = hi_region ? base1 : base0;
  end
endmodule

// File: rtl/xw_desc_decode.sv
module xw_desc_decode
  import xw_pkg::*;
#(
  parameter int LEVEL = 1
) (
  input  logic [31:0] desc,
  input  logic [31:0] va,
  output xw_dec_t     dec
);
  localparam int PTR_ALIGN = 10;

  generate
    if (LEVEL == 1) begin : g_first
      always_comb begin
        dec = '0;
        unique case (desc[1:0])
          2'b01: begin
            dec.next    = 1'b1;
            dec.l2_base = {desc[31:PTR_ALIGN], {PTR_ALIGN{1'b0}}};
          end
          2'b10: begin
            if (desc[18]) begin
              dec.kind = KIND_SUPER;
              dec.pa   = {desc[15:8], desc[31:24], va[23:0]};
            end else begin
              dec.kind = KIND_SECTION;
              dec.pa   = {8'h00, desc[31:20], va[19:0]};
            end
          end
          default: dec.fault = 1'b1;
        endcase
      end
    end else begin : g_second
      always_comb begin
        dec = '0;
        if (desc[1]) begin
          dec.kind = KIND_SMALL;
          dec.pa   = {8'h00, desc[31:12], va[11:0]};
        end else if (desc[0]) begin
          dec.kind = KIND_LARGE;
          dec.pa   = {8'h00, desc[31:16], va[15:0]};
        end else begin
          dec.fault = 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/xw_walker.sv
module xw_walker
  import xw_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 40,
  parameter int NSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSEL_W-1:0] ctl_split_n,
  input  logic [VA_W-1:0]   ctl_base0,
  input  logic [VA_W-1:0]   ctl_base1,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [1:0]        rsp_kind,
  output logic              rsp_fault,
  output logic              rsp_fault_lvl,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [VA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data
);
  localparam int L1_IDX_W = 12;
  localparam int L2_IDX_W = 8;
  localparam int DESC_SH  = 2;
  localparam int L1_PAD   = VA_W - L1_IDX_W - DESC_SH;
  localparam int L2_PAD   = VA_W - L2_IDX_W - DESC_SH;

  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_RESP
  } state_e;

  state_e          state_q;
  logic [VA_W-1:0] va_q, base_q, l2_base_q, sel_base;
  logic [PA_W-1:0] pa_q;
  xw_kind_e        kind_q;
  logic            fault_q, lvl_q;
  xw_dec_t         dec1, dec2;

  xw_base_sel #(.VA_W(VA_W), .NSEL_W(NSEL_W)) u_sel (
    .va(req_va), .split_n(ctl_split_n),
    .base0(ctl_base0), .base1(ctl_base1), .base(sel_base)
  );

  xw_desc_decode #(.LEVEL(1)) u_dec1 (.desc(mem_rsp_data), .va(va_q), .dec(dec1));
  xw_desc_decode #(.LEVEL(2)) u_dec2 (.desc(mem_rsp_data), .va(va_q), .dec(dec2));

  assign req_ready     = (state_q == S_IDLE);
  assign rsp_valid     = (state_q == S_RESP);
  assign mem_req_valid = (state_q == S_L1_REQ) || (state_q == S_L2_REQ);
  assign rsp_pa        = pa_q;
  assign rsp_kind      = kind_q;
  assign rsp_fault     = fault_q;
  assign rsp_fault_lvl = lvl_q;

  always_comb begin
    if (state_q == S_L2_REQ)
      mem_req_addr = l2_base_q + {{L2_PAD{1'b0}}, va_q[19:12], {DESC_SH{1'b0}}};
    else
      mem_req_addr = base_q + {{L1_PAD{1'b0}}, va_q[31:20], {DESC_SH{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      va_q      <= '0;
      base_q    <= '0;
      l2_base_q <= '0;
      pa_q      <= '0;
      kind_q    <= KIND_SECTION;
      fault_q   <= 1'b0;
      lvl_q     <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid) begin
          va_q    <= req_va;
          base_q  <= sel_base;
          state_q <= S_L1_REQ;
        end
        S_L1_REQ: if (mem_req_ready) state_q <= S_L1_WAIT;
        S_L1_WAIT: if (mem_rsp_valid) begin
          if (dec1.next) begin
            l2_base_q <= dec1.l2_base;
            state_q   <= S_L2_REQ;
          end else begin
            fault_q <= dec1.fault;
            lvl_q   <= 1'b0;
            pa_q    <= dec1.fault ? '0 : dec1.pa;
            kind_q  <= dec1.kind;
            state_q <= S_RESP;
          end
        end
        S_L2_REQ: if (mem_req_ready) state_q <= S_L2_WAIT;
        S_L2_WAIT: if (mem_rsp_valid) begin
          fault_q <= dec2.fault;
          lvl_q   <= dec2.fault;
          pa_q    <= dec2.fault ? '0 : dec2.pa;
          kind_q  <= dec2.kind;
          state_q <= S_RESP;
        end
        S_RESP: if (rsp_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_fault)
      && $stable(rsp_kind) && $stable(rsp_fault_lvl));
  // R10
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  // R11
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !rsp_valid && !req_ready);
  // R8
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_pa == '0);
  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault && rsp_kind != KIND_SUPER |-> rsp_pa[PA_W-1:32] == '0);
endmodule

// File: tb/xw_walker_bench.sv
module xw_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ctl_split_n = '0;
  logic [31:0] ctl_base0 = 32'h0004_0000;
  logic [31:0] ctl_base1 = 32'h0800_C000;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [39:0] rsp_pa;
  logic [1:0]  rsp_kind;
  logic        rsp_fault, rsp_fault_lvl;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0, fails = 0, cyc = 0, reads = 0, bad_addr = 0;
  logic        stall_mode = 1'b0;
  logic [31:0] l1_desc, l2_desc, exp_l1_addr, exp_l2_addr;

  always #2 clk = ~clk;

  xw_walker u_xw_walker (
    .clk(clk), .rst_n(rst_n), .ctl_split_n(ctl_split_n),
    .ctl_base0(ctl_base0), .ctl_base1(ctl_base1),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
    .rsp_kind(rsp_kind), .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  assign mem_req_ready = stall_mode ? cyc[0] : 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      reads <= reads + 1;
      mem_rsp_valid <= 1'b1;
      if (mem_req_addr == exp_l1_addr) mem_rsp_data <= l1_desc;
      else if (mem_req_addr == exp_l2_addr) mem_rsp_data <= l2_desc;
      else begin
        bad_addr <= bad_addr + 1;
        mem_rsp_data <= 32'h0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected<150000", cyc);
    finish_run();
  end

  // one walk: ty selects the descriptor pattern
  task automatic walk(input logic [2:0] n, input logic [31:0] va, input int ty, input logic [31:0] seed, input bit bp);
    logic [31:0] base, l2b;
    logic [39:0] e_pa;
    logic [1:0]  e_kind;
    bit          e_fault, e_lvl;
    int          e_reads, r0, b0;
    logic [39:0] held;
    bit          hi = (n != 0) && ((va >> (6'd32 - {3'd0, n})) != 0);
    base = hi ? ctl_base1 : ctl_base0;                      // R1
    exp_l1_addr = base + {18'd0, va[31:20], 2'b00};
    l1_desc = seed; l2_desc = ~seed;
    e_fault = 0; e_lvl = 0; e_reads = 1; e_pa = '0; e_kind = 0;
    case (ty)
      0: begin l1_desc[1:0] = 2'b00; e_fault = 1; end      // R2 R8
      1: begin l1_desc[1:0] = 2'b11; e_fault = 1; end      // R2 R8
      2: begin l1_desc[1:0] = 2'b10; l1_desc[18] = 0;      // R3
         e_pa = {8'h00, l1_desc[31:20], va[19:0]}; e_kind = 0; end
      3: begin l1_desc[1:0] = 2'b10; l1_desc[18] = 1;      // R4
         e_pa = {l1_desc[15:8], l1_desc[31:24], va[23:0]}; e_kind = 1; end
      default: begin
        l1_desc[1:0] = 2'b01; e_reads = 2;
        l2b = {l1_desc[31:10], 10'b0};                     // R5
        case (ty)
          4: begin l2_desc[1:0] = 2'b00; e_fault = 1; e_lvl = 1; end
          5: begin l2_desc[1:0] = 2'b01;                    // R7
             e_pa = {8'h00, l2_desc[31:16], va[15:0]}; e_kind = 2; end
          6: begin l2_desc[1:0] = 2'b10;                    // R6
             e_pa = {8'h00, l2_desc[31:12], va[11:0]}; e_kind = 3; end
          default: begin l2_desc[1:0] = 2'b11;
             e_pa = {8'h00, l2_desc[31:12], va[11:0]}; e_kind = 3; end
        endcase
      end
    endcase
    exp_l2_addr = (e_reads == 2) ? l2b + {22'd0, va[19:12], 2'b00} : 32'hFFFF_FFFF;
    @(negedge clk);
    ctl_split_n = n; req_va = va; req_valid = 1'b1;
    r0 = reads; b0 = bad_addr;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    while (!rsp_valid) begin
      check(!req_ready, "R10 busy", {63'd0, req_ready}, 64'd0);
      @(negedge clk);
    end
    held = rsp_pa;
    if (bp) begin
      repeat (2) @(negedge clk);
      check(rsp_valid && rsp_pa == held && !req_ready, "R10 hold", {24'd0, rsp_pa}, {24'd0, held});
    end
    check(bad_addr == b0, "R1 R5 read address", 64'(bad_addr - b0), 64'd0);
    check(reads - r0 == e_reads, "R11 read count", 64'(reads - r0), 64'(e_reads));
    check(rsp_fault == e_fault, "R2 R8 fault", {63'd0, rsp_fault}, {63'd0, e_fault});
    check(rsp_pa == e_pa, "R3 R4 R6 R7 R9 pa", {24'd0, rsp_pa}, {24'd0, e_pa});
    if (e_fault) check(rsp_fault_lvl == e_lvl, "R8 level", {63'd0, rsp_fault_lvl}, {63'd0, e_lvl});
    else check(rsp_kind == e_kind, "R3 R4 R6 R7 kind", {62'd0, rsp_kind}, {62'd0, e_kind});
    rsp_ready = 1'b1;
    @(posedge clk); #1 rsp_ready = 1'b0;
  endtask

  initial begin
    logic [31:0] vas [8];
    vas = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0010_0ABC, 32'h8000_0000,
            32'h0200_3456, 32'h1234_5678, 32'h4FED_CBA9, 32'h0300_F00D};
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req_valid, "R10 reset",
          {61'd0, req_ready, rsp_valid, mem_req_valid}, 64'h4);
    rst_n = 1'b1;
    for (int n = 0; n < 8; n++)
      for (int v = 0; v < 8; v++)
        for (int t = 0; t < 8; t++) begin
          stall_mode = ((n + v + t) % 3) == 0;
          walk(3'(n), vas[v], t, (vas[v] * 32'h9E37_79B9) ^ {8'(t), 24'hA5C3E1},
               ((v + t) % 4) == 1);
        end
    finish_run();
  end
endmodule